// File: doc/BRIEF.md
# Monochrome glyph to pixel expander

This block converts a one-bit-per-pixel glyph into a stream of colored pixels covering a rectangle. A caller presents the glyph width, height, foreground color and background color together with a one-cycle `start` pulse. The block then pulls 32-bit words of bitmap data over a valid/ready handshake. It emits one pixel per accepted output beat, tagged with its x/y position inside the rectangle and a last flag. A set bit yields the foreground color and a clear bit yields the background color.

The bitmap is one continuous bit string. A row does not start on a byte or word boundary. Bits left over at the end of one row are the first bits of the next row. Only the bitmap as a whole is padded, up to a whole number of 32-bit words. Any padding bits after the final pixel are consumed and dropped.

The controller has three states. `ST_IDLE` waits for `start`. It moves to `ST_FETCH` when the size is non-zero, and stays in `ST_IDLE` when the width or height is zero. `ST_FETCH` asserts `in_ready` and moves to `ST_EMIT` when a word is accepted. `ST_EMIT` presents pixels from the held word. When the final pixel is accepted it returns to `ST_IDLE`. When the 32nd pixel of the word is accepted it returns to `ST_FETCH`. Otherwise it stays in `ST_EMIT`.

Top module: `glyph_expand`

## Requirements
- R1: After reset, `idle` is 1 and both `out_valid` and `in_ready` are 0.
- R2: A bitmap bit of 1 produces a pixel equal to the foreground color. A bit of 0 produces the background color.
- R3: Pixel k of the glyph comes from word k/32. Within that word, with p = k mod 32, the bit is taken from byte p/8, where byte 0 is bits 7:0. Inside the byte, bit 7 is the leftmost pixel, so the word bit index is 8*(p/8) + 7 - (p mod 8).
- R4: Rows are not padded. Pixel (x, y) uses bit index k = y*width + x, including rows that begin in the middle of a word.
- R5: Pixels are emitted in row-major order starting at (0,0). `out_x` and `out_y` give the position, and they always stay below the width and the height.
- R6: `out_last` is 1 only on the pixel at (width-1, height-1). After that pixel is accepted the block is idle again.
- R7: Exactly ceil(width*height/32) words are accepted per glyph. Padding bits are discarded. `in_ready` stays 0 after the final pixel until the next `start`.
- R8: A width or height of zero emits no pixel, accepts no word, and leaves `idle` at 1.
- R9: While `out_valid` is 1 and `out_ready` is 0, the output pixel, x and y hold steady and `out_valid` stays 1.
- R10: A `start` pulse while a glyph is in progress has no effect. The current glyph finishes with its original size and colors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a glyph using the cfg_* values (taken only when idle) |
| cfg_width | input | DIM_W | Glyph width in pixels |
| cfg_height | input | DIM_W | Glyph height in pixels |
| cfg_fg | input | PIX_W | Color for set bits |
| cfg_bg | input | PIX_W | Color for clear bits |
| idle | output | 1 | No glyph in progress |
| in_valid | input | 1 | Bitmap word available |
| in_data | input | 32 | Bitmap word |
| in_ready | output | 1 | Block accepts a bitmap word |
| out_valid | output | 1 | Pixel available |
| out_ready | input | 1 | Consumer accepts the pixel |
| out_pix | output | PIX_W | Pixel color |
| out_x | output | DIM_W | Pixel column |
| out_y | output | DIM_W | Pixel row |
| out_last | output | 1 | Final pixel of the glyph |

## Verification
The assertions assume that reset is applied before any traffic. They also assume that the cfg_* values matter only in the cycle where `start` is taken while idle. Neither handshake input is assumed to be well behaved: `in_valid` and `out_ready` may drop or rise in any cycle. The stimulus changes inputs only on the falling clock edge. It stalls both handshakes in regular patterns, keeps extra words offered after a glyph's final pixel so that over-consumption would show, and pulses `start` with different settings in the middle of a glyph.

// File: rtl/glyph_pkg.sv
package glyph_pkg;
    localparam int WORD_BITS = 32;
    localparam int BYTE_BITS = 8;
    localparam int PTR_W     = $clog2(WORD_BITS);
    localparam int LANE_W    = $clog2(BYTE_BITS);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_EMIT  = 2'd2
    } gx_state_e;
endpackage

// File: rtl/glyph_bit_pick.sv
module glyph_bit_pick
    import glyph_pkg::*;
(
    input  logic [WORD_BITS-1:0] word,
    input  logic [PTR_W-1:0]     idx,
    output logic                 bit_o
);
    // Byte lanes are taken from the low end of the word; within a lane
    // the pixel order runs from the top bit down.
    logic [PTR_W-1:0] sel;

    always_comb begin
        sel = {idx[PTR_W-1:LANE_W], ~idx[LANE_W-1:0]};
        bit_o = word[sel];
    end
endmodule

// File: rtl/glyph_raster.sv
module glyph_raster #(
    parameter int DIM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [DIM_W-1:0] width,
    input  logic [DIM_W-1:0] height,
    output logic [DIM_W-1:0] x,
    output logic [DIM_W-1:0] y,
    output logic             at_end
);
    logic row_end;

    always_comb begin
        row_end = (x == width - DIM_W'(1));
        at_end  = row_end && (y == height - DIM_W'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            x <= '0;
            y <= '0;
        end else if (step) begin
            if (row_end) begin
                x <= '0;
                y <= y + DIM_W'(1);
            end else begin
                x <= x + DIM_W'(1);
            end
        end
    end
endmodule

// File: rtl/glyph_expand.sv
module glyph_expand
    import glyph_pkg::*;
#(
    parameter int PIX_W = 24,
    parameter int DIM_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [DIM_W-1:0]     cfg_width,
    input  logic [DIM_W-1:0]     cfg_height,
    input  logic [PIX_W-1:0]     cfg_fg,
    input  logic [PIX_W-1:0]     cfg_bg,
    output logic                 idle,
    input  logic                 in_valid,
    input  logic [WORD_BITS-1:0] in_data,
    output logic                 in_ready,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [PIX_W-1:0]     out_pix,
    output logic [DIM_W-1:0]     out_x,
    output logic [DIM_W-1:0]     out_y,
    output logic                 out_last
);
    localparam logic [PTR_W-1:0] PTR_TOP = PTR_W'(WORD_BITS - 1);

    gx_state_e state_q, state_d;

    logic [DIM_W-1:0]     width_q, height_q;
    logic [PIX_W-1:0]     fg_q, bg_q;
    logic [WORD_BITS-1:0] word_q;
    logic [PTR_W-1:0]     ptr_q;
    logic                 cur_bit;
    logic                 launch;
    logic                 take_word;
    logic                 take_pix;
    logic                 at_end;

    assign launch    = (state_q == ST_IDLE) && start;
    assign take_word = in_valid && in_ready;
    assign take_pix  = out_valid && out_ready;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start && (cfg_width != '0) && (cfg_height != '0))
                    state_d = ST_FETCH;
            end
            ST_FETCH: begin
                if (in_valid) state_d = ST_EMIT;
            end
            ST_EMIT: begin
                if (out_ready) begin
                    if (at_end)                state_d = ST_IDLE;
                    else if (ptr_q == PTR_TOP) state_d = ST_FETCH;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        idle      = 1'b0;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:  idle      = 1'b1;
            ST_FETCH: in_ready  = 1'b1;
            ST_EMIT:  out_valid = 1'b1;
            default:  idle      = 1'b1;
        endcase
        out_pix  = cur_bit ? fg_q : bg_q;
        out_last = out_valid && at_end;
    end

    // Datapath: glyph settings, held word, bit pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_q  <= '0;
            height_q <= '0;
            fg_q     <= '0;
            bg_q     <= '0;
            word_q   <= '0;
            ptr_q    <= '0;
        end else begin
            if (launch) begin
                width_q  <= cfg_width;
                height_q <= cfg_height;
                fg_q     <= cfg_fg;
                bg_q     <= cfg_bg;
            end
            if (take_word) begin
                word_q <= in_data;
                ptr_q  <= '0;
            end else if (take_pix) begin
                ptr_q <= ptr_q + PTR_W'(1);
            end
        end
    end

    glyph_bit_pick u_pick (
        .word  (word_q),
        .idx   (ptr_q),
        .bit_o (cur_bit)
    );

    glyph_raster #(.DIM_W(DIM_W)) u_raster (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (launch),
        .step   (take_pix),
        .width  (width_q),
        .height (height_q),
        .x      (out_x),
        .y      (out_y),
        .at_end (at_end)
    );

    // R9: a stalled pixel must not change
    assert_hold_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pix) && $stable(out_x) && $stable(out_y)));

    // R5: coordinates remain inside the rectangle
    assert_coord_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_x < width_q) && (out_y < height_q)));

    // R6: accepting the final pixel returns the block to idle
    assert_last_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_pix && out_last) |=> (idle && !in_ready && !out_valid));

    // R8: an idle block neither requests words nor offers pixels
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!in_ready && !out_valid));

    // R7: words are never requested while a pixel is pending
    assert_one_side_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));
endmodule

// File: tb/glyph_expand_tb.sv
module glyph_expand_tb;
    localparam int PIX_W = 24;
    localparam int DIM_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [DIM_W-1:0] cfg_width = '0;
    logic [DIM_W-1:0] cfg_height = '0;
    logic [PIX_W-1:0] cfg_fg = '0;
    logic [PIX_W-1:0] cfg_bg = '0;
    logic             idle;
    logic             in_valid = 1'b0;
    logic [31:0]      in_data = '0;
    logic             in_ready;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [PIX_W-1:0] out_pix;
    logic [DIM_W-1:0] out_x;
    logic [DIM_W-1:0] out_y;
    logic             out_last;

    int checks = 0;
    int fails  = 0;
    logic [31:0] wmem [0:15];

    always #4 clk = ~clk;

    glyph_expand #(.PIX_W(PIX_W), .DIM_W(DIM_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_width(cfg_width), .cfg_height(cfg_height),
        .cfg_fg(cfg_fg), .cfg_bg(cfg_bg), .idle(idle),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix),
        .out_x(out_x), .out_y(out_y), .out_last(out_last)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_glyph(input string tag, input int w, input int h,
                             input logic [PIX_W-1:0] fg, input logic [PIX_W-1:0] bg,
                             input int seed, input bit stall, input bit restart);
        int total = w * h;
        int nwords = (total + 31) / 32;
        int k = 0;
        int wi = 0;
        int cyc = 0;
        int post = 0;
        bit prev_stall = 0;
        logic [PIX_W-1:0] hp = '0;
        logic [DIM_W-1:0] hx = '0, hy = '0;
        for (int i = 0; i < 16; i++)
            wmem[i] = (32'h9E37_79B9 * (i + 1 + seed)) ^ (32'h5A5A_0F0F << (i % 7));
        @(negedge clk);
        cfg_width = DIM_W'(w); cfg_height = DIM_W'(h);
        cfg_fg = fg; cfg_bg = bg; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (post < 8) begin
            in_valid  = stall ? (cyc % 2 == 0) : 1'b1;
            in_data   = (wi < 16) ? wmem[wi] : 32'hFFFF_FFFF;
            out_ready = stall ? (cyc % 3 != 1) : 1'b1;
            if (restart && cyc == 6) begin
                start = 1'b1; cfg_width = 1; cfg_height = 1; cfg_fg = ~fg; cfg_bg = ~bg;
            end else begin
                start = 1'b0;
            end
            #2;
            if (prev_stall) begin
                chk(out_valid && out_pix == hp && out_x == hx && out_y == hy,
                    "R9", "stalled pixel held", {out_x, out_y, out_pix}, {hx, hy, hp});
            end
            prev_stall = out_valid && !out_ready;
            hp = out_pix; hx = out_x; hy = out_y;
            if (out_valid && out_ready) begin
                if (k >= total) begin
                    chk(0, "R7", "pixel beyond glyph", k, total);
                end else begin
                    int p = k % 32;
                    int b = (p / 8) * 8 + 7 - (p % 8);
                    logic [PIX_W-1:0] ex = wmem[k / 32][b] ? fg : bg;
                    chk(out_pix == ex, tag, "pixel color", out_pix, ex);
                    chk(out_x == DIM_W'(k % w) && out_y == DIM_W'(k / w), "R5",
                        "coordinates", {out_x, out_y}, {8'(k % w), 8'(k / w)});
                    chk(out_last == (k == total - 1), "R6", "last flag", out_last, k == total - 1);
                end
                k++;
            end
            if (in_valid && in_ready) wi++;
            if (k >= total) post++;
            cyc++;
            @(negedge clk);
        end
        in_valid = 1'b0; out_ready = 1'b0; start = 1'b0;
        #2;
        chk(wi == nwords, "R7", "words consumed", wi, nwords);
        chk(idle && !in_ready && !out_valid, "R6", "idle after glyph", {idle, in_ready, out_valid}, 3'b100);
    endtask

    task automatic test_reset();
        #2;
        chk(idle == 1'b1 && out_valid == 1'b0 && in_ready == 1'b0, "R1", "reset state",
            {idle, out_valid, in_ready}, 3'b100);
    endtask

    task automatic test_zero(input int w, input int h);
        int acc = 0;
        int pix = 0;
        @(negedge clk);
        cfg_width = DIM_W'(w); cfg_height = DIM_W'(h); start = 1'b1;
        in_valid = 1'b1; in_data = 32'h1234_5678; out_ready = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 12; c++) begin
            #2;
            if (in_valid && in_ready) acc++;
            if (out_valid) pix++;
            @(negedge clk);
        end
        in_valid = 1'b0; out_ready = 1'b0;
        #2;
        chk(acc == 0, "R8", "words taken for empty glyph", acc, 0);
        chk(pix == 0, "R8", "pixels for empty glyph", pix, 0);
        chk(idle == 1'b1, "R8", "idle after empty glyph", idle, 1);
    endtask

    initial begin
        #(8 * 100000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        run_glyph("R2", 8, 4, 24'hFF8800, 24'h001122, 1, 0, 0);
        run_glyph("R3", 32, 1, 24'hABCDEF, 24'h102030, 7, 0, 0);
        run_glyph("R4", 5, 7, 24'h00FF00, 24'h0000FF, 3, 0, 0);
        run_glyph("R4", 13, 9, 24'h7F7F7F, 24'h808080, 11, 1, 0);
        test_zero(0, 5);
        test_zero(6, 0);
        run_glyph("R10", 10, 3, 24'h123456, 24'h654321, 5, 0, 1);
        run_glyph("R2", 1, 1, 24'hFFFFFF, 24'h000000, 9, 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule